// File: doc/BRIEF.md
# Tiled Bilinear Texel Address Generator

This block turns one texture sample request into the four memory addresses of the 2x2 texel footprint that a bilinear filter needs. It also returns the two fractional weights that the filter blends with. A request carries a u/v coordinate pair in unsigned 16.8 fixed point and a mip level number. The texture description travels alongside each request and is captured with it: a base address, the log2 of the level-0 width and height, and a tile ordering select.

Texels are stored in square tiles of 2^TILE_LOG2 x 2^TILE_LOG2 texels, so one tile fills one cache line. All texels of a tile are stored before the next tile starts. Inside a tile the texels are in row-major order. The tiles of a level are placed either in row-major order or in Z-order (Morton order). Mip levels halve in each dimension and are stored one after another from the base address, level 0 first. A level smaller than a tile still takes one whole tile. Coordinates that leave the texture wrap around, so the texture repeats. Addresses count texels.

The block is a two-stage pipeline. It has a valid/ready handshake at its input and at its output, and it accepts one request per clock.

Top module: `texel_quad_addrgen`

## Requirements
- R1: `out_addr` holds four addresses. Slice k sits at bits [32k+31:32k]. Slice 0 is (x0,y0), slice 1 is (x1,y0), slice 2 is (x0,y1) and slice 3 is (x1,y1). When the level is at least 2 texels wide and 2 texels high, the four addresses are distinct.
- R2: The sample point is the coordinate minus half a texel (0x80 in 16.8 format). x0 is the integer part of that point and x1 = x0+1. `out_frac_u` is the low 8 bits of that point. The same rules apply to v, y0, y1 and `out_frac_v`.
- R3: Texel indices wrap modulo the level width and the level height. At the right edge x1 wraps to 0. A coordinate below 0.5 gives x0 = width-1. A coordinate far beyond the texture repeats it.
- R4: The address of a texel inside its level is tile_index*T*T + (y mod T)*T + (x mod T), where T = 2^TILE_LOG2 (8 by default).
- R5: When `tex_zorder` is 0, tile_index = ty*tiles_x + tx. Here tx = x/T, ty = y/T and tiles_x = max(1, level_width/T).
- R6: When `tex_zorder` is 1, the tile index is built by interleaving. Bit i of tx goes to index bit 2i and bit i of ty goes to bit 2i+1, for each i below m = min(log2 tiles_x, log2 tiles_y). The remaining higher bits of the larger tile coordinate go to index bits m+i.
- R7: For level L, log2 of the level width is max(`tex_log2_w` - L, 0), and the height follows the same rule. A level past both dimensions is 1x1, and all four addresses are then equal.
- R8: The base of level L is `tex_base` plus the sum, over all lower levels, of tiles_x*tiles_y*T*T. A level smaller than one tile occupies one full tile.
- R9: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Its result appears two clock edges later. While `out_ready` stays high, one result is produced per clock, in order.
- R10: While `out_valid` is high and `out_ready` is low, the outputs hold steady. Two requests can be held. `req_ready` then falls, and no request is lost or reordered.
- R11: After reset, `out_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_u | input | 24 | u coordinate, unsigned 16.8 |
| req_v | input | 24 | v coordinate, unsigned 16.8 |
| req_level | input | 4 | Mip level number |
| tex_base | input | 32 | Texel address of level 0 |
| tex_log2_w | input | 4 | log2 of the level-0 width |
| tex_log2_h | input | 4 | log2 of the level-0 height |
| tex_zorder | input | 1 | 1 selects Z-order tile placement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 128 | Four corner addresses |
| out_frac_u | output | 8 | Horizontal bilinear weight |
| out_frac_v | output | 8 | Vertical bilinear weight |

## Verification
Two things can happen in the same cycle: an output stall, and the arrival of a new request at the input. The bench holds `out_ready` low while requests keep arriving, until both stages are full. It then releases the stall in the same cycle that a third request is waiting. The bench judges this by three facts. `req_ready` must drop only once both stages are occupied. The stalled output must not change. The three results must come out in order and equal the values computed by the reference. Within a single footprint, a horizontal wrap and a tile crossing also fall together, and they are checked under both tile orderings.

// File: rtl/tqa_pkg.sv
// Shared helpers for the tiled bilinear texel address generator.
// Assumes that all dimensions are powers of two and are given as log2 values.
package tqa_pkg;

    typedef enum logic {
        TILE_ROWMAJ = 1'b0,
        TILE_ZORDER = 1'b1
    } tile_order_e;

    // log2 of one dimension at a mip level, never below a single texel
    function automatic int lvl_dim_log(int base_log, int lvl);
        return (base_log > lvl) ? base_log - lvl : 0;
    endfunction

    // log2 of the number of tiles along one dimension, never below one tile
    function automatic int tile_grid_log(int dim_log, int tile_log);
        return (dim_log > tile_log) ? dim_log - tile_log : 0;
    endfunction

endpackage

// File: rtl/tqa_coord_wrap.sv
// One axis of coordinate handling. It applies the half-texel offset, splits
// the result into an integer part and a fraction, and wraps the two
// neighbouring texel indices into a power-of-two extent.
// Assumes XW <= CI, and dim_log <= XW.
module tqa_coord_wrap #(
    parameter int CI   = 16,
    parameter int FW   = 8,
    parameter int XW   = 10,
    parameter int LOGW = 4
) (
    input  logic [CI+FW-1:0] coord,
    input  logic [LOGW-1:0]  dim_log,
    output logic [XW-1:0]    idx_lo,
    output logic [XW-1:0]    idx_hi,
    output logic [FW-1:0]    frac
);
    localparam int CW   = CI + FW;
    localparam int HALF = 1 << (FW - 1);

    logic [CW-1:0] shifted;
    logic [CI-1:0] ipart;
    logic [XW-1:0] mask;

    // offset by half a texel, then split and wrap
    always_comb begin
        shifted = coord - CW'(HALF);
        ipart   = shifted[CW-1:FW];
        frac    = shifted[FW-1:0];
        mask    = (XW'(1) << dim_log) - XW'(1);
        idx_lo  = ipart[XW-1:0] & mask;
        idx_hi  = (idx_lo + XW'(1)) & mask;
    end
endmodule

// File: rtl/tqa_level_base.sv
// Finds where a mip level starts and how large it is. The sizes of all
// lower levels are summed by an unrolled adder chain, and each level is
// padded up to whole tiles. Also returns the level's log2 dimensions.
// Assumes the request level fits in LVLW bits.
module tqa_level_base
    import tqa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LOGW   = 4,
    parameter int LVLW   = 4,
    parameter int TL     = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LOGW-1:0]   log_w,
    input  logic [LOGW-1:0]   log_h,
    input  logic [LVLW-1:0]   level,
    output logic [ADDR_W-1:0] lvl_base,
    output logic [ADDR_W-1:0] lvl_size,
    output logic [LOGW-1:0]   lvl_log_w,
    output logic [LOGW-1:0]   lvl_log_h
);
    localparam int NLVL = 1 << LVLW;

    // add up the padded size of every level below the requested one
    always_comb begin
        logic [ADDR_W-1:0] acc;
        int gx;
        int gy;
        acc = base;
        for (int i = 0; i < NLVL; i++) begin
            gx = tile_grid_log(lvl_dim_log(int'(log_w), i), TL);
            gy = tile_grid_log(lvl_dim_log(int'(log_h), i), TL);
            if (i < int'(level))
                acc = acc + (ADDR_W'(1) << (gx + gy + 2 * TL));
        end
        lvl_base = acc;
    end

    // dimensions and padded size of the requested level itself
    always_comb begin
        lvl_log_w = LOGW'(lvl_dim_log(int'(log_w), int'(level)));
        lvl_log_h = LOGW'(lvl_dim_log(int'(log_h), int'(level)));
        lvl_size  = ADDR_W'(1) << (tile_grid_log(int'(lvl_log_w), TL)
                                 + tile_grid_log(int'(lvl_log_h), TL) + 2 * TL);
    end
endmodule

// File: rtl/tqa_tile_map.sv
// Maps one wrapped texel (x,y) to its offset inside its mip level. The tile
// index is placed in row-major or Z-order, and the texel sits row-major
// inside its tile.
// Assumes x < 2^log_w and y < 2^log_h, which the coordinate wrap guarantees.
module tqa_tile_map
    import tqa_pkg::*;
#(
    parameter int XW     = 10,
    parameter int LOGW   = 4,
    parameter int TL     = 3,
    parameter int ADDR_W = 32
) (
    input  logic [XW-1:0]     x,
    input  logic [XW-1:0]     y,
    input  logic [LOGW-1:0]   log_w,
    input  logic [LOGW-1:0]   log_h,
    input  tile_order_e       order,
    output logic [ADDR_W-1:0] offset
);
    localparam int IW = 2 * XW;

    logic [XW-1:0] tx;
    logic [XW-1:0] ty;
    logic [IW-1:0] tidx;
    logic [2*TL-1:0] intra;

    // tile index in the selected ordering
    always_comb begin
        int gx;
        int gy;
        int m;
        tx   = x >> TL;
        ty   = y >> TL;
        gx   = tile_grid_log(int'(log_w), TL);
        gy   = tile_grid_log(int'(log_h), TL);
        m    = (gx < gy) ? gx : gy;
        tidx = '0;
        if (order == TILE_ZORDER) begin
            for (int i = 0; i < XW; i++) begin
                if (i < m) begin
                    tidx[2*i]   = tx[i];
                    tidx[2*i+1] = ty[i];
                end else if (m + i < IW) begin
                    tidx[m+i] = tx[i] | ty[i];
                end
            end
        end else begin
            tidx = (IW'(ty) << gx) | IW'(tx);
        end
    end

    // combine the tile index with the texel position inside the tile
    always_comb begin
        intra  = {y[TL-1:0], x[TL-1:0]};
        offset = (ADDR_W'(tidx) << (2 * TL)) | ADDR_W'(intra);
    end
endmodule

// File: rtl/texel_quad_addrgen.sv
// Top of the tiled bilinear texel address generator. Stage 1 wraps the
// coordinates and finds the level base. Stage 2 places the four corners in
// the tiled layout. Both stages stall under a valid/ready chain.
// Assumes the texture fields are valid for as long as req_valid is high.
module texel_quad_addrgen
    import tqa_pkg::*;
#(
    parameter int CI           = 16,
    parameter int FW           = 8,
    parameter int LOG2_MAX_DIM = 10,
    parameter int TILE_LOG2    = 3,
    parameter int LVLW         = 4,
    parameter int ADDR_W       = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CI+FW-1:0]      req_u,
    input  logic [CI+FW-1:0]      req_v,
    input  logic [LVLW-1:0]       req_level,
    input  logic [ADDR_W-1:0]     tex_base,
    input  logic [$clog2(LOG2_MAX_DIM+1)-1:0] tex_log2_w,
    input  logic [$clog2(LOG2_MAX_DIM+1)-1:0] tex_log2_h,
    input  logic                  tex_zorder,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [4*ADDR_W-1:0]   out_addr,
    output logic [FW-1:0]         out_frac_u,
    output logic [FW-1:0]         out_frac_v
);
    localparam int XW   = LOG2_MAX_DIM;
    localparam int LOGW = $clog2(LOG2_MAX_DIM + 1);
    localparam int NCOR = 4;

    // stage 1 inputs, computed from the request
    logic [XW-1:0]     c_x0, c_x1, c_y0, c_y1;
    logic [FW-1:0]     c_fu, c_fv;
    logic [ADDR_W-1:0] c_base, c_size;
    logic [LOGW-1:0]   c_lw, c_lh;

    // stage 1 registers
    logic              s1_v;
    logic [XW-1:0]     s1_x0, s1_x1, s1_y0, s1_y1;
    logic [FW-1:0]     s1_fu, s1_fv;
    logic [ADDR_W-1:0] s1_base, s1_size;
    logic [LOGW-1:0]   s1_lw, s1_lh;
    tile_order_e       s1_order;

    // stage 2 registers
    logic              s2_v;
    logic [ADDR_W-1:0] s2_addr [NCOR];
    logic [FW-1:0]     s2_fu, s2_fv;

    logic              s1_ready, s2_ready;
    logic [ADDR_W-1:0] off [NCOR];

    tqa_level_base #(.ADDR_W(ADDR_W), .LOGW(LOGW), .LVLW(LVLW), .TL(TILE_LOG2)) u_lvl (
        .base(tex_base), .log_w(tex_log2_w), .log_h(tex_log2_h), .level(req_level),
        .lvl_base(c_base), .lvl_size(c_size), .lvl_log_w(c_lw), .lvl_log_h(c_lh)
    );

    tqa_coord_wrap #(.CI(CI), .FW(FW), .XW(XW), .LOGW(LOGW)) u_wrap_u (
        .coord(req_u), .dim_log(c_lw), .idx_lo(c_x0), .idx_hi(c_x1), .frac(c_fu)
    );

    tqa_coord_wrap #(.CI(CI), .FW(FW), .XW(XW), .LOGW(LOGW)) u_wrap_v (
        .coord(req_v), .dim_log(c_lh), .idx_lo(c_y0), .idx_hi(c_y1), .frac(c_fv)
    );

    // ready chain: a stage may load when it is empty or draining
    always_comb begin
        s2_ready  = !s2_v || out_ready;
        s1_ready  = !s1_v || s2_ready;
        req_ready = s1_ready;
    end

    // stage 1: capture the wrapped coordinates, weights and level geometry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
        end else if (s1_ready) begin
            s1_v <= req_valid;
            if (req_valid) begin
                s1_x0    <= c_x0;
                s1_x1    <= c_x1;
                s1_y0    <= c_y0;
                s1_y1    <= c_y1;
                s1_fu    <= c_fu;
                s1_fv    <= c_fv;
                s1_base  <= c_base;
                s1_size  <= c_size;
                s1_lw    <= c_lw;
                s1_lh    <= c_lh;
                s1_order <= tex_zorder ? TILE_ZORDER : TILE_ROWMAJ;
            end
        end
    end

    // one tile mapper per footprint corner: bit 0 picks x1, bit 1 picks y1
    for (genvar k = 0; k < NCOR; k++) begin : g_corner
        tqa_tile_map #(.XW(XW), .LOGW(LOGW), .TL(TILE_LOG2), .ADDR_W(ADDR_W)) u_map (
            .x((k % 2 == 1) ? s1_x1 : s1_x0),
            .y((k / 2 == 1) ? s1_y1 : s1_y0),
            .log_w(s1_lw), .log_h(s1_lh), .order(s1_order),
            .offset(off[k])
        );

        // R8
        tile_in_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s1_v |-> off[k] < s1_size);

        assign out_addr[k*ADDR_W +: ADDR_W] = s2_addr[k];
    end

    // stage 2: add the level base to each corner offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0;
        end else if (s2_ready) begin
            s2_v <= s1_v;
            if (s1_v) begin
                for (int k = 0; k < NCOR; k++)
                    s2_addr[k] <= s1_base + off[k];
                s2_fu <= s1_fu;
                s2_fv <= s1_fv;
            end
        end
    end

    // drive the output port from stage 2
    always_comb begin
        out_valid  = s2_v;
        out_frac_u = s2_fu;
        out_frac_v = s2_fv;
    end

    // R1
    quad_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_lw != '0 && s1_lh != '0) |-> (off[0] != off[3] && off[1] != off[2]));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> s1_v);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_frac_u) && $stable(out_frac_v)));
endmodule

// File: tb/tb_texel_quad_addrgen.sv
`timescale 1ns/1ps
module tb_texel_quad_addrgen;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [23:0]  req_u, req_v;
    logic [3:0]   req_level;
    logic [31:0]  tex_base;
    logic [3:0]   tex_log2_w, tex_log2_h;
    logic         tex_zorder;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_addr;
    logic [7:0]   out_frac_u, out_frac_v;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    texel_quad_addrgen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_u(req_u), .req_v(req_v), .req_level(req_level), .tex_base(tex_base),
        .tex_log2_w(tex_log2_w), .tex_log2_h(tex_log2_h), .tex_zorder(tex_zorder),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_frac_u(out_frac_u), .out_frac_v(out_frac_v)
    );

    // reference address of corner (cx,cy), built from the requirements
    function automatic logic [31:0] ref_addr(logic [31:0] base, int lw0, int lh0, bit zo,
                                             int lvl, logic [23:0] u, logic [23:0] v,
                                             int cx, int cy);
        int lw, lh, gx, gy, x, y, tx, ty, m, idx;
        longint acc;
        logic [23:0] su, sv;
        lw  = (lw0 > lvl) ? lw0 - lvl : 0;
        lh  = (lh0 > lvl) ? lh0 - lvl : 0;
        acc = longint'(base);
        for (int i = 0; i < lvl; i++) begin
            int a, b;
            a = (lw0 > i) ? lw0 - i : 0;
            b = (lh0 > i) ? lh0 - i : 0;
            a = (a > 3) ? a - 3 : 0;
            b = (b > 3) ? b - 3 : 0;
            acc += longint'(64) * (longint'(1) << (a + b));
        end
        su = u - 24'd128;
        sv = v - 24'd128;
        x  = (int'(su[23:8]) + cx) % (1 << lw);
        y  = (int'(sv[23:8]) + cy) % (1 << lh);
        tx = x / 8;
        ty = y / 8;
        gx = (lw > 3) ? lw - 3 : 0;
        gy = (lh > 3) ? lh - 3 : 0;
        if (zo) begin
            m   = (gx < gy) ? gx : gy;
            idx = 0;
            for (int i = 0; i < 10; i++) begin
                if (i < m) begin
                    idx |= ((tx >> i) & 1) << (2 * i);
                    idx |= ((ty >> i) & 1) << (2 * i + 1);
                end else begin
                    idx |= (((tx | ty) >> i) & 1) << (m + i);
                end
            end
        end else begin
            idx = ty * (1 << gx) + tx;
        end
        return 32'(acc + longint'(idx) * 64 + longint'((y % 8) * 8 + (x % 8)));
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // compare the current output with the reference for one request
    task automatic cmp_out(string tag, logic [23:0] u, logic [23:0] v, int lvl);
        logic [23:0] su, sv;
        for (int k = 0; k < 4; k++)
            check({tag, " addr"}, out_addr[k*32 +: 32],
                  ref_addr(tex_base, int'(tex_log2_w), int'(tex_log2_h), tex_zorder,
                           lvl, u, v, k % 2, k / 2));
        su = u - 24'd128;
        sv = v - 24'd128;
        check({tag, " frac"}, {16'd0, out_frac_u, out_frac_v}, {16'd0, su[7:0], sv[7:0]});
    endtask

    // send one request, wait for its result and check it
    task automatic run_one(string tag, logic [23:0] u, logic [23:0] v, int lvl);
        @(negedge clk);
        out_ready = 1'b1;
        req_u = u; req_v = v; req_level = 4'(lvl); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 8 && !out_valid; i++) @(negedge clk);
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        cmp_out(tag, u, v, lvl);
    endtask

    task automatic set_tex(logic [31:0] b, int lw, int lh, bit zo);
        tex_base = b; tex_log2_w = 4'(lw); tex_log2_h = 4'(lh); tex_zorder = zo;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R11 req_ready after reset", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic t_basic();
        set_tex(32'h1000_0000, 6, 6, 1'b0);
        run_one("R1 R4 R5 inner texel", 24'h000580, 24'h000380, 0);
        run_one("R4 R5 tile crossing x", 24'h000800, 24'h000380, 0);
        run_one("R4 R5 tile crossing y", 24'h002A80, 24'h001000, 0);
    endtask

    task automatic t_fraction();
        set_tex(32'h0000_4000, 6, 6, 1'b0);
        run_one("R2 quarter weights", 24'h000CC0, 24'h000940, 0);
        run_one("R2 zero weight", 24'h001080, 24'h001180, 0);
    endtask

    task automatic t_wrap();
        set_tex(32'h0000_0000, 6, 6, 1'b0);
        run_one("R3 below half texel", 24'h000040, 24'h000010, 0);
        run_one("R3 right edge", 24'h003FC0, 24'h000500, 0);
        run_one("R3 far repeat", 24'hFFFF80, 24'h043380, 0);
    endtask

    task automatic t_mip();
        set_tex(32'h2000_0000, 6, 6, 1'b0);
        run_one("R7 R8 level 1", 24'h000580, 24'h000780, 1);
        run_one("R7 R8 level 2", 24'h000A80, 24'h000E00, 2);
        run_one("R8 padded level 4", 24'h000280, 24'h000180, 4);
        run_one("R7 one texel level 9", 24'h001234, 24'h005678, 9);
    endtask

    task automatic t_zorder();
        set_tex(32'h0100_0000, 6, 6, 1'b1);
        run_one("R6 zorder square", 24'h002880, 24'h001480, 0);
        run_one("R6 zorder tile crossing", 24'h001800, 24'h002000, 0);
        set_tex(32'h0100_0000, 7, 4, 1'b1);
        run_one("R6 R7 zorder wide", 24'h005A80, 24'h000900, 0);
        set_tex(32'h0100_0000, 7, 4, 1'b0);
        run_one("R5 R7 rowmajor wide", 24'h005A80, 24'h000900, 0);
    endtask

    task automatic t_edge_combo();
        set_tex(32'h0300_0000, 6, 6, 1'b1);
        run_one("R3 R6 wrap with zorder", 24'h003FB0, 24'h000F90, 0);
        set_tex(32'h0300_0000, 5, 6, 1'b1);
        run_one("R3 R6 R8 wrap at level 1", 24'h000FC0, 24'h001F90, 1);
    endtask

    // back-to-back stream: one result per clock after two edges
    task automatic t_stream();
        logic [23:0] us [4];
        logic [23:0] vs [4];
        set_tex(32'h0000_8000, 6, 6, 1'b0);
        us = '{24'h000180, 24'h000980, 24'h001180, 24'h001980};
        vs = '{24'h000280, 24'h000A80, 24'h001280, 24'h001A80};
        out_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R9 stream valid", {31'd0, out_valid}, 32'd1);
                cmp_out("R9 stream order", us[i-2], vs[i-2], 0);
            end
            if (i < 4) begin
                check("R9 stream ready", {31'd0, req_ready}, 32'd1);
                req_u = us[i]; req_v = vs[i]; req_level = 4'd0; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    // stall with new requests arriving, then release while one is waiting
    task automatic t_stall();
        logic [23:0] ua, ub, uc;
        logic [127:0] held;
        set_tex(32'h0000_0400, 6, 6, 1'b0);
        ua = 24'h000380; ub = 24'h001380; uc = 24'h002380;
        @(negedge clk);
        out_ready = 1'b0;
        req_u = ua; req_v = 24'h000480; req_level = 4'd0; req_valid = 1'b1;
        @(negedge clk);
        check("R10 ready with one held", {31'd0, req_ready}, 32'd1);
        req_u = ub;
        @(negedge clk);
        req_u = uc;
        check("R10 ready low when full", {31'd0, req_ready}, 32'd0);
        check("R10 stalled valid", {31'd0, out_valid}, 32'd1);
        cmp_out("R10 stalled first", ua, 24'h000480, 0);
        held = out_addr;
        repeat (3) @(negedge clk);
        check("R10 held addr", held[31:0], out_addr[31:0]);
        check("R10 still not ready", {31'd0, req_ready}, 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cmp_out("R10 second after release", ub, 24'h000480, 0);
        @(negedge clk);
        cmp_out("R10 third after release", uc, 24'h000480, 0);
        @(negedge clk);
        check("R10 drained", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b1;
        req_u = '0; req_v = '0; req_level = '0;
        set_tex(32'h0, 6, 6, 1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_fraction();
        t_wrap();
        t_mip();
        t_zorder();
        t_edge_combo();
        t_stream();
        t_stall();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule